// File: doc/BRIEF.md
# Static Memory Bank Strobe Sequencer

This block turns a single request (address, write flag, write data) into the timed strobe sequence that an asynchronous ROM or SRAM bank expects. After a request is accepted, the block drives the bank strobes in a fixed order. The address becomes valid first. Chip select follows after a programmable set-up time, and output enable (read) or write enable (write) follows after a second set-up time. The strobe stays low for the access interval. Chip select is then held for a programmable time, and the address is held for a further programmable time. Every interval is a small code that maps to a clock count through its own non-linear table.

Reads can run in page mode. A run of 1, 4, 8 or 16 consecutive words is fetched while chip select and output enable stay low. The first word uses the normal access time and every following word uses a separate, shorter page access time. The word address steps by one for each new word. Read data is captured on the last clock of each word and reduced to the configured data width. When the wait input is enabled, the memory can stretch an access by holding the wait input high. The configuration inputs are expected to stay stable while the block is busy.

Top module: `sram_strobe_seq`

## Requirements
- R1: After reset the block is idle: `mem_cs_n`, `mem_oe_n` and `mem_we_n` are high, `mem_addr_vld`, `busy`, `done` and `rd_vld` are low.
- R2: After a request is accepted, the address is valid with chip select high for a number of clocks given by `cfg_adr_setup`: code 0, 1, 2, 3 gives 0, 1, 2, 4 clocks.
- R3: Chip select is low before output enable or write enable falls, for a number of clocks given by `cfg_sel_setup` using the 0/1/2/4 table.
- R4: The access strobe (output enable for reads, write enable for writes) is low for `cfg_acc_code` clocks: codes 0 to 7 give 1, 2, 3, 4, 6, 8, 10, 14 clocks.
- R5: Chip select stays low after the access strobe rises, for a number of clocks given by `cfg_sel_hold` using the 0/1/2/4 table.
- R6: The address stays valid after chip select rises, for a number of clocks given by `cfg_adr_hold` using the 0/1/2/4 table.
- R7: A read performs a run of words set by `cfg_pg_run`: code 0, 1, 2, 3 gives 1, 4, 8, 16. Each word after the first adds `cfg_pg_code` clocks: code 0, 1, 2, 3 gives 2, 3, 4, 6. Chip select and output enable stay low across the run, and `mem_addr` increments by one for each word.
- R8: Each read word is captured from `mem_rdata` on the last clock of its access. It appears on `rd_data` with a one-cycle `rd_vld` in the next cycle, zero-extended from the width set by `cfg_width`: code 0 keeps bits 7:0, code 1 keeps bits 15:0, code 2 keeps all 32 bits.
- R9: A request made while `cfg_width` is 3 (reserved) is ignored. No strobe moves, `busy` stays low and no `done` follows.
- R10: With `cfg_wait_en` high, an access does not end on a clock where `mem_wait` is high, so the strobe lasts the longer of the access time and the wait. With `cfg_wait_en` low, `mem_wait` has no effect.
- R11: `done` is a one-cycle pulse in the cycle after the address hold ends. `busy` is high from acceptance through that cycle, and requests made while busy are ignored.
- R12: A write performs exactly one access whatever the page run code. `mem_wdata` carries the request's data while write enable is low, and output enable and write enable are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_adr_setup | input | 2 | Address set-up before chip select code |
| cfg_sel_setup | input | 2 | Chip-select set-up before strobe code |
| cfg_acc_code | input | 3 | Access interval code |
| cfg_sel_hold | input | 2 | Chip-select hold after strobe code |
| cfg_adr_hold | input | 2 | Address hold after chip select code |
| cfg_pg_code | input | 2 | Page word access time code |
| cfg_pg_run | input | 2 | Page run length code |
| cfg_wait_en | input | 1 | Lets `mem_wait` stretch accesses |
| cfg_width | input | 2 | Data width code (3 reserved) |
| req | input | 1 | Request, taken when idle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address of the request |
| req_wdata | input | 32 | Write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_vld | output | 1 | Read word valid pulse |
| rd_data | output | 32 | Captured, width-reduced read word |
| mem_addr | output | AW | Bank address |
| mem_addr_vld | output | 1 | Address valid strobe |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_wdata | output | 32 | Bank write data |
| mem_rdata | input | 32 | Bank read data |
| mem_wait | input | 1 | Wait request from the bank, active high |

## Verification
The assertions check the strobe nesting on every cycle: an access strobe only inside chip select, and chip select only inside address valid. They also check that output enable and write enable are never low together, that write data is stable during a write, that the done pulse is one cycle on an idle bus, that reserved-width requests are refused, and that an asserted wait never lets a read strobe end. The exact clock counts of each code table, the page-run word count and address stepping, the width masking of captured data, and the independence from `mem_wait` when waiting is disabled can only be shown by the bench scenarios. These scenarios measure every phase length and compare every captured word.

// File: rtl/sram_strobe_seq.sv
module sram_strobe_seq #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cfg_adr_setup,
  input  logic [1:0]    cfg_sel_setup,
  input  logic [2:0]    cfg_acc_code,
  input  logic [1:0]    cfg_sel_hold,
  input  logic [1:0]    cfg_adr_hold,
  input  logic [1:0]    cfg_pg_code,
  input  logic [1:0]    cfg_pg_run,
  input  logic          cfg_wait_en,
  input  logic [1:0]    cfg_width,
  input  logic          req,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic          busy,
  output logic          done,
  output logic          rd_vld,
  output logic [31:0]   rd_data,
  output logic [AW-1:0] mem_addr,
  output logic          mem_addr_vld,
  output logic          mem_cs_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_wait
);

  typedef enum logic [2:0] {
    S_IDLE, S_AS, S_CS, S_ACC, S_PG, S_CH, S_AH, S_DONE
  } st_t;

  st_t           st, nx, first;
  logic [3:0]    cnt;
  logic [3:0]    beats_q;
  logic          we_q;
  logic [1:0]    wid_q;
  logic [AW-1:0] addr_q;
  logic [31:0]   wdata_q;
  logic          in_acc, stall, phase_end;

  function automatic logic [3:0] set_clks(input logic [1:0] c);
    return (c == 2'd3) ? 4'd4 : {2'b00, c};
  endfunction

  function automatic logic [3:0] acc_clks(input logic [2:0] c);
    case (c)
      3'd0: return 4'd1;
      3'd1: return 4'd2;
      3'd2: return 4'd3;
      3'd3: return 4'd4;
      3'd4: return 4'd6;
      3'd5: return 4'd8;
      3'd6: return 4'd10;
      default: return 4'd14;
    endcase
  endfunction

  function automatic logic [3:0] pg_clks(input logic [1:0] c);
    return (c == 2'd3) ? 4'd6 : {2'b00, c} + 4'd2;
  endfunction

  function automatic logic [3:0] run_extra(input logic [1:0] c);
    case (c)
      2'd0: return 4'd0;
      2'd1: return 4'd3;
      2'd2: return 4'd7;
      default: return 4'd15;
    endcase
  endfunction

  function automatic logic [3:0] len_m1(input st_t s);
    case (s)
      S_AS:    return set_clks(cfg_adr_setup) - 4'd1;
      S_CS:    return set_clks(cfg_sel_setup) - 4'd1;
      S_ACC:   return acc_clks(cfg_acc_code) - 4'd1;
      S_PG:    return pg_clks(cfg_pg_code) - 4'd1;
      S_CH:    return set_clks(cfg_sel_hold) - 4'd1;
      S_AH:    return set_clks(cfg_adr_hold) - 4'd1;
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic [31:0] narrow(input logic [31:0] d, input logic [1:0] w);
    case (w)
      2'd0:    return {24'd0, d[7:0]};
      2'd1:    return {16'd0, d[15:0]};
      default: return d;
    endcase
  endfunction

  assign in_acc    = (st == S_ACC) || (st == S_PG);
  assign stall     = in_acc && cfg_wait_en && mem_wait;
  assign phase_end = (cnt == 4'd0) && !stall;

  always_comb begin
    first = (cfg_adr_setup != 2'd0) ? S_AS :
            (cfg_sel_setup != 2'd0) ? S_CS : S_ACC;
    case (st)
      S_AS:         nx = (cfg_sel_setup != 2'd0) ? S_CS : S_ACC;
      S_CS:         nx = S_ACC;
      S_ACC, S_PG:  nx = (cfg_sel_hold != 2'd0) ? S_CH :
                         (cfg_adr_hold != 2'd0) ? S_AH : S_DONE;
      S_CH:         nx = (cfg_adr_hold != 2'd0) ? S_AH : S_DONE;
      default:      nx = S_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      beats_q <= '0;
      we_q    <= 1'b0;
      wid_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rd_vld  <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_vld <= 1'b0;
      case (st)
        S_IDLE: if (req && cfg_width != 2'd3) begin
          addr_q  <= req_addr;
          we_q    <= req_we;
          wdata_q <= req_wdata;
          wid_q   <= cfg_width;
          beats_q <= req_we ? 4'd0 : run_extra(cfg_pg_run);
          st      <= first;
          cnt     <= len_m1(first);
        end
        S_DONE: st <= S_IDLE;
        default: begin
          if (phase_end) begin
            if (in_acc && !we_q) begin
              rd_data <= narrow(mem_rdata, wid_q);
              rd_vld  <= 1'b1;
            end
            if (in_acc && beats_q != 4'd0) begin
              st      <= S_PG;
              cnt     <= len_m1(S_PG);
              addr_q  <= addr_q + 1'b1;
              beats_q <= beats_q - 4'd1;
            end else begin
              st  <= nx;
              cnt <= len_m1(nx);
            end
          end else if (cnt != 4'd0) begin
            cnt <= cnt - 4'd1;
          end
        end
      endcase
    end
  end

  assign busy         = (st != S_IDLE);
  assign done         = (st == S_DONE);
  assign mem_addr     = addr_q;
  assign mem_wdata    = wdata_q;
  assign mem_addr_vld = (st != S_IDLE) && (st != S_DONE);
  assign mem_cs_n     = !((st == S_CS) || in_acc || (st == S_CH));
  assign mem_oe_n     = !(in_acc && !we_q);
  assign mem_we_n     = !((st == S_ACC) && we_q);

  a_r3_strobe_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> !mem_cs_n);

  a_r6_cs_in_addr: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> mem_addr_vld);

  a_r12_oe_we_excl: assert property (@(posedge clk) disable iff (!rst_n)
    mem_oe_n || mem_we_n);

  a_r12_wdata_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && !$past(mem_we_n)) |-> $stable(mem_wdata));

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r11_done_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!mem_addr_vld && mem_cs_n));

  a_r9_reserved_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !busy && cfg_width == 2'd3) |=> !busy);

  a_r10_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wait_en && mem_wait && !mem_oe_n) |=> !mem_oe_n);

endmodule

// File: tb/sim_sram_strobe_seq.sv
module sim_sram_strobe_seq;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_adr_setup = '0, cfg_sel_setup = '0, cfg_sel_hold = '0, cfg_adr_hold = '0;
  logic [1:0] cfg_pg_code = '0, cfg_pg_run = '0, cfg_width = 2'd2;
  logic [2:0] cfg_acc_code = '0;
  logic cfg_wait_en = 1'b0, req = 1'b0, req_we = 1'b0, mem_wait = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic busy, done, rd_vld, mem_addr_vld, mem_cs_n, mem_oe_n, mem_we_n;
  logic [31:0] rd_data, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_addr;

  int checks = 0, bad = 0, cyc = 0;

  always #4 clk = ~clk;

  function automatic logic [31:0] model(input logic [AW-1:0] a);
    return {a[7:0] ^ 8'h5A, a[7:0], ~a[7:0], a[7:0] + 8'h33};
  endfunction

  assign mem_rdata = model(mem_addr);

  sram_strobe_seq #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_adr_setup(cfg_adr_setup), .cfg_sel_setup(cfg_sel_setup),
    .cfg_acc_code(cfg_acc_code), .cfg_sel_hold(cfg_sel_hold),
    .cfg_adr_hold(cfg_adr_hold), .cfg_pg_code(cfg_pg_code),
    .cfg_pg_run(cfg_pg_run), .cfg_wait_en(cfg_wait_en), .cfg_width(cfg_width),
    .req(req), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rd_vld(rd_vld), .rd_data(rd_data),
    .mem_addr(mem_addr), .mem_addr_vld(mem_addr_vld), .mem_cs_n(mem_cs_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_wait(mem_wait)
  );

  function automatic int t4(input logic [1:0] c);
    return (c == 2'd3) ? 4 : int'(c);
  endfunction
  function automatic int tacc(input logic [2:0] c);
    case (c)
      3'd0: return 1; 3'd1: return 2; 3'd2: return 3; 3'd3: return 4;
      3'd4: return 6; 3'd5: return 8; 3'd6: return 10; default: return 14;
    endcase
  endfunction
  function automatic int tpg(input logic [1:0] c);
    return (c == 2'd3) ? 6 : int'(c) + 2;
  endfunction
  function automatic int nrun(input logic [1:0] c);
    return (c == 2'd0) ? 1 : (c == 2'd1) ? 4 : (c == 2'd2) ? 8 : 16;
  endfunction
  function automatic logic [31:0] mask(input logic [31:0] d, input logic [1:0] w);
    return (w == 2'd0) ? {24'd0, d[7:0]} : (w == 2'd1) ? {16'd0, d[15:0]} : d;
  endfunction

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  // fields: we, adr_setup, sel_setup, acc, sel_hold, adr_hold, pg, run, width
  localparam logic [17:0] VEC [8] = '{
    {1'b0, 2'd0, 2'd0, 3'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd2},
    {1'b0, 2'd1, 2'd1, 3'd1, 2'd1, 2'd1, 2'd0, 2'd0, 2'd2},
    {1'b0, 2'd2, 2'd3, 3'd7, 2'd3, 2'd2, 2'd0, 2'd0, 2'd1},
    {1'b0, 2'd3, 2'd2, 3'd4, 2'd0, 2'd3, 2'd0, 2'd1, 2'd0},
    {1'b0, 2'd1, 2'd0, 3'd2, 2'd1, 2'd0, 2'd3, 2'd2, 2'd2},
    {1'b0, 2'd0, 2'd1, 3'd5, 2'd2, 2'd1, 2'd1, 2'd3, 2'd2},
    {1'b1, 2'd2, 2'd1, 3'd3, 2'd1, 2'd2, 2'd2, 2'd3, 2'd2},
    {1'b1, 2'd0, 2'd0, 3'd6, 2'd3, 2'd0, 2'd0, 2'd0, 2'd1}
  };

  task automatic run_op(input logic [17:0] v, input logic [AW-1:0] a,
                        input logic [31:0] wd, input bit wen, input int w, input bit hold);
    int av = 0, cs = 0, oe = 0, wec = 0, nb = 0, idx = 0, fcs = -1, fst = -1;
    int wbad = 0, dbad = 0, dn = 0, n, accs, stb;
    @(negedge clk);
    req_we = v[17]; cfg_adr_setup = v[16:15]; cfg_sel_setup = v[14:13];
    cfg_acc_code = v[12:10]; cfg_sel_hold = v[9:8]; cfg_adr_hold = v[7:6];
    cfg_pg_code = v[5:4]; cfg_pg_run = v[3:2]; cfg_width = v[1:0];
    cfg_wait_en = wen; req_addr = a; req_wdata = wd; mem_wait = (w > 0); req = 1'b1;
    @(negedge clk);
    if (!hold) req = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      if (mem_addr_vld) av++;
      if (!mem_cs_n) begin cs++; if (fcs < 0) fcs = idx; end
      if ((!mem_oe_n || !mem_we_n) && fst < 0) fst = idx;
      if (!mem_oe_n) oe++;
      if (!mem_we_n) begin wec++; if (mem_wdata !== wd) wbad++; end
      if (rd_vld) begin
        if (rd_data !== mask(model(a + AW'(nb)), v[1:0])) begin
          dbad++;
          $display("FAIL R8 word %0d actual=%h expected=%h", nb, rd_data,
                   mask(model(a + AW'(nb)), v[1:0]));
        end
        nb++;
      end
      if (done) begin dn = 1; break; end
      idx++;
      mem_wait = (w > oe + wec);
      @(negedge clk);
    end
    req = 1'b0; mem_wait = 1'b0;
    n = v[17] ? 1 : nrun(v[3:2]);
    accs = tacc(v[12:10]);
    if (wen && w > accs) accs = w;
    stb = accs + (n - 1) * tpg(v[5:4]);
    chk("R2 cs start", fcs, t4(v[16:15]));
    chk("R3 strobe start", fst, t4(v[16:15]) + t4(v[14:13]));
    chk("R4/R10 strobe length", v[17] ? wec : oe, stb);
    chk("R12 no oe on write / no we on read", v[17] ? oe : wec, 0);
    chk("R5 cs hold", cs - t4(v[14:13]) - stb, t4(v[9:8]));
    chk("R6 addr hold", av - cs - t4(v[16:15]), t4(v[7:6]));
    chk("R7 words", nb, v[17] ? 0 : n);
    chk("R8 data errors", dbad, 0);
    chk("R12 write data", wbad, 0);
    chk("R11 done seen", dn, 1);
    chk("R11 done timing", idx, av);
    @(negedge clk);
    chk("R11 done pulse ends", {30'd0, busy, done}, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      $display("test done: total=%0d bad=%0d", checks + 1, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset cs_n", mem_cs_n, 1);
    chk("R1 reset oe_n/we_n", {mem_oe_n, mem_we_n}, 3);
    chk("R1 reset idle", {mem_addr_vld, busy, done, rd_vld}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (VEC[k]) run_op(VEC[k], AW'(16'h0100 + 16'(k) * 16'h0020), 32'hC0DE0000 + 32'(k), 1'b0, 0, 1'b0);

    // R10: wait stretches when enabled, ignored when disabled
    run_op({1'b0, 2'd1, 2'd1, 3'd1, 2'd1, 2'd1, 2'd0, 2'd0, 2'd2}, 16'h0040, 32'd0, 1'b1, 5, 1'b0);
    run_op({1'b0, 2'd1, 2'd1, 3'd1, 2'd1, 2'd1, 2'd0, 2'd0, 2'd2}, 16'h0041, 32'd0, 1'b0, 5, 1'b0);
    run_op({1'b0, 2'd0, 2'd0, 3'd3, 2'd0, 2'd0, 2'd0, 2'd0, 2'd2}, 16'h0042, 32'd0, 1'b1, 1, 1'b0);
    run_op({1'b1, 2'd0, 2'd1, 3'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd2}, 16'h0043, 32'h1234ABCD, 1'b1, 4, 1'b0);

    // R11: request held high during the whole sequence gives one sequence
    run_op({1'b0, 2'd1, 2'd0, 3'd2, 2'd0, 2'd1, 2'd0, 2'd0, 2'd2}, 16'h00F0, 32'd0, 1'b0, 0, 1'b1);

    // R7: page run wrapping the low address byte
    run_op({1'b0, 2'd0, 2'd0, 3'd0, 2'd0, 2'd0, 2'd0, 2'd1, 2'd2}, 16'h00FE, 32'd0, 1'b0, 0, 1'b0);

    // R9: reserved width code is refused
    @(negedge clk);
    cfg_width = 2'd3; req_we = 1'b0; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    begin
      int act = 0;
      for (int i = 0; i < 6; i++) begin
        if (busy || done || mem_addr_vld || !mem_cs_n || !mem_oe_n) act++;
        @(negedge clk);
      end
      chk("R9 reserved width activity", act, 0);
    end

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule